// File: doc/BRIEF.md
# Daisy-Chained Front-End Readout Slave

This block is the digital readout and rate-monitor port of one front-end card in a chain of cards that share a single set of control lines. A trigger strobe reaching every card at once freezes that card's hit pattern into a 48-bit frame. The frame holds a strapped board identifier, 32 strip hits, four coincidence-fold flags and one timing bit. A 4-bit address and a mode line then pick one card. In event mode the chosen card shifts its frame onto the serial line, one bit per falling edge of the serial clock. Cards that are not chosen pass the upstream serial data straight through.

In monitor mode the chosen card routes one of 40 internal signals onto the monitor line, so that a scaler further down the chain can measure its rate. The 40 signals are the strips, the folds, the timing bit and three calibration inputs. The first monitor-clock pulse after the card is selected enables it. Each later pulse moves to the next signal. A monitor-reset pulse returns the selection to the first signal. Cards that are not chosen forward the upstream monitor signal.

All strobes are level inputs that are already synchronous to `clk`. The block detects their edges itself.

Top module: `fe_readout_slave`

## Requirements
- R1: After synchronous reset, the frame register holds all zeros. The monitor selector is disabled and points at the first signal, and `mon_last_o` is low.
- R2: A rising edge on `trig_i` loads the frame in every mode and at every address. Frame bit order, most significant bit first: `board_id_i[7:0]`, then `hits_i[31]` down to `hits_i[0]`, then `fold_i[3]` down to `fold_i[0]`, then `tdc_i`, then three zero bits. `hits_i[k-1]` is strip k and `fold_i[j-1]` is the j-fold flag.
- R3: When `mode_evt_i` is 1 and `addr_i` equals `my_addr_i`, `sout_o` shows the leading frame bit. Each falling edge of `sclk_i` advances the frame by one bit and shifts `sin_i` into the tail, so after 48 shifts `sout_o` carries upstream data. Without a shift or a load, `sout_o` holds.
- R4: When the card is not selected for event mode, `sout_o` equals `sin_i`, and falling edges of `sclk_i` leave the frame unchanged.
- R5: In monitor mode (`mode_evt_i` 0, address match), `mout_o` forwards `min_i` until the first rising edge of `mclk_i`. That edge enables the card at signal index 0. Index encoding: 0..31 is `hits_i[0..31]`, 32..35 is `fold_i[0..3]`, 36 is `tdc_i`, and 37..39 is `cal_i[0..2]`. While enabled, `mout_o` is the indexed signal.
- R6: Each further rising edge of `mclk_i` on an enabled card advances the index by one.
- R7: The index saturates at 39. `mon_last_o` is high exactly while the card is selected, enabled and at index 39.
- R8: `mrst_i` high on a selected card returns the index to 0 and takes priority over `mclk_i`. An enabled card stays enabled.
- R9: A card that is not selected for monitor mode drives `mout_o` equal to `min_i` and `mon_last_o` low, and it loses its enable. After it is selected again, it needs a new enabling pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| board_id_i | input | 8 | Strapped board identifier |
| my_addr_i | input | 4 | Strapped chain address of this card |
| addr_i | input | 4 | Address broadcast on the chain |
| mode_evt_i | input | 1 | 1 = event readout, 0 = monitoring |
| trig_i | input | 1 | Trigger strobe, rising edge latches the frame |
| hits_i | input | 32 | Strip hit signals |
| fold_i | input | 4 | Fold flags, bit j-1 is j-fold |
| tdc_i | input | 1 | Timing signal |
| cal_i | input | 3 | Calibration signals for monitoring |
| sclk_i | input | 1 | Serial readout clock, falling edge shifts |
| sin_i | input | 1 | Serial data from the upstream card |
| sout_o | output | 1 | Serial data to the downstream card |
| mclk_i | input | 1 | Monitor clock, rising edge enables or steps |
| mrst_i | input | 1 | Monitor reset to the first signal |
| min_i | input | 1 | Monitor signal from the upstream card |
| mout_o | output | 1 | Monitor signal to the downstream card |
| mon_last_o | output | 1 | Selector is at the final signal |

## Verification
A frame register that is off by one position shows up as a wrong bit on `sout_o` in the first readout cycle after the trigger. The full frame is compared bit by bit, so a misordered field fails before the 48th shift. A monitor index that skips, wraps or misses its enable shows the wrong strip on `mout_o` one clock after the offending `mclk_i` edge. An enable that survives deselection shows up the moment the card is selected again, because `mout_o` fails to forward `min_i`.

// File: rtl/fe_ro_pkg.sv
// Shared sizing constants for the front-end readout slave.
package fe_ro_pkg;
    localparam int FE_CH_N   = 32;  // strips per card
    localparam int FE_FOLD_N = 4;   // fold flags
    localparam int FE_CAL_N  = 3;   // calibration inputs for monitoring
    localparam int FE_ID_W   = 8;   // board identifier width
    localparam int FE_ADDR_W = 4;   // chain address width
    localparam int FE_PAD_N  = 3;   // zero pad bits at the frame tail
endpackage

// File: rtl/fe_ro_edge.sv
// Single-strobe edge detector.
// Assumes the strobe is already synchronous to clk. The previous-sample
// register follows its input even during reset, so that the first edge
// after reset is seen exactly as the chain drove it.
module fe_ro_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic lvl_i,
    output logic edge_o
);
    logic lvl_q;

    // Purpose: remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        lvl_q <= lvl_i;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = lvl_q & ~lvl_i;
        end else begin : g_rise
            assign edge_o = ~lvl_q & lvl_i;
        end
    endgenerate
endmodule

// File: rtl/fe_ro_frame_sr.sv
// Parallel-load, serial-out frame register.
// A load takes priority over a shift. A shift moves the frame toward the
// most significant bit and fills the tail from the serial input.
module fe_ro_frame_sr #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    input  logic         sin_i,
    output logic         msb_o
);
    logic [W-1:0] sr_q;

    // Purpose: hold, load or advance the latched frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= word_i;
        end else if (shift_i) begin
            sr_q <= {sr_q[W-2:0], sin_i};
        end
    end

    assign msb_o = sr_q[W-1];
endmodule

// File: rtl/fe_ro_mon_sel.sv
// Sequential monitor-channel selector.
// Assumes sel_i is high only while this card is addressed in monitor mode.
// The first step after selection enables the card at index 0. Later steps
// advance the index and saturate at N-1. A clear returns the index to 0,
// and deselection drops the enable.
module fe_ro_mon_sel #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_i,
    input  logic         step_i,
    input  logic         clr_i,
    input  logic [N-1:0] sigs_i,
    input  logic         min_i,
    output logic         mout_o,
    output logic         last_o
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] IDX_TOP = IW'(N - 1);

    logic          en_q;
    logic [IW-1:0] idx_q;

    // Purpose: update the enable flag and the selected index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            idx_q <= '0;
        end else if (!sel_i) begin
            en_q  <= 1'b0;
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (step_i) begin
            if (!en_q) begin
                en_q  <= 1'b1;
                idx_q <= '0;
            end else if (idx_q != IDX_TOP) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Purpose: drive the selected signal or forward the upstream line.
    always_comb begin
        mout_o = (sel_i && en_q) ? sigs_i[idx_q] : min_i;
        last_o = sel_i && en_q && (idx_q == IDX_TOP);
    end
endmodule

// File: rtl/fe_readout_slave.sv
// Front-end readout slave: one card of a daisy chain.
// Assumes all strobes are synchronous to clk and wider than one clk cycle.
// It latches the frame on a trigger, shifts it out when addressed in event
// mode, and steps a monitor selector when addressed in monitor mode.
module fe_readout_slave
    import fe_ro_pkg::*;
#(
    parameter int CH_N   = FE_CH_N,
    parameter int FOLD_N = FE_FOLD_N,
    parameter int CAL_N  = FE_CAL_N,
    parameter int ID_W   = FE_ID_W,
    parameter int ADDR_W = FE_ADDR_W,
    parameter int PAD_N  = FE_PAD_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   board_id_i,
    input  logic [ADDR_W-1:0] my_addr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode_evt_i,
    input  logic              trig_i,
    input  logic [CH_N-1:0]   hits_i,
    input  logic [FOLD_N-1:0] fold_i,
    input  logic              tdc_i,
    input  logic [CAL_N-1:0]  cal_i,
    input  logic              sclk_i,
    input  logic              sin_i,
    output logic              sout_o,
    input  logic              mclk_i,
    input  logic              mrst_i,
    input  logic              min_i,
    output logic              mout_o,
    output logic              mon_last_o
);
    localparam int FRAME_W = ID_W + CH_N + FOLD_N + 1 + PAD_N;
    localparam int MON_N   = CH_N + FOLD_N + 1 + CAL_N;

    logic               hit_me;
    logic               sel_evt;
    logic               sel_mon;
    logic               trig_rise;
    logic               sclk_fall;
    logic               mclk_rise;
    logic               frame_msb;
    logic [FRAME_W-1:0] frame_word;
    logic [MON_N-1:0]   mon_sigs;

    // Purpose: decode the broadcast address and mode for this card.
    always_comb begin
        hit_me  = (addr_i == my_addr_i);
        sel_evt = hit_me && mode_evt_i;
        sel_mon = hit_me && !mode_evt_i;
    end

    fe_ro_edge #(.FALLING(1'b0)) u_trig_edge (
        .clk(clk), .lvl_i(trig_i), .edge_o(trig_rise)
    );
    fe_ro_edge #(.FALLING(1'b1)) u_sclk_edge (
        .clk(clk), .lvl_i(sclk_i), .edge_o(sclk_fall)
    );
    fe_ro_edge #(.FALLING(1'b0)) u_mclk_edge (
        .clk(clk), .lvl_i(mclk_i), .edge_o(mclk_rise)
    );

    // Purpose: assemble the frame (leading bit first) and the monitor vector.
    always_comb begin
        frame_word = {board_id_i, hits_i, fold_i, tdc_i, {PAD_N{1'b0}}};
        mon_sigs   = {cal_i, tdc_i, fold_i, hits_i};
    end

    fe_ro_frame_sr #(.W(FRAME_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (trig_rise),
        .word_i  (frame_word),
        .shift_i (sel_evt && sclk_fall),
        .sin_i   (sin_i),
        .msb_o   (frame_msb)
    );

    // Purpose: drive this card's frame bit when selected, else bypass.
    always_comb begin
        sout_o = sel_evt ? frame_msb : sin_i;
    end

    fe_ro_mon_sel #(.N(MON_N)) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_mon),
        .step_i (mclk_rise),
        .clr_i  (mrst_i),
        .sigs_i (mon_sigs),
        .min_i  (min_i),
        .mout_o (mout_o),
        .last_o (mon_last_o)
    );
endmodule

// File: rtl/fe_readout_slave_chk.sv
// Property checker for the readout slave; it observes ports only.
module fe_readout_slave_chk #(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   board_id_i,
    input logic [ADDR_W-1:0] my_addr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              mode_evt_i,
    input logic              trig_i,
    input logic              sclk_i,
    input logic              mrst_i,
    input logic              sout_o,
    input logic              mon_last_o
);
    logic sel_evt;
    logic sel_mon;

    // Purpose: local view of the card selection.
    always_comb begin
        sel_evt = (addr_i == my_addr_i) && mode_evt_i;
        sel_mon = (addr_i == my_addr_i) && !mode_evt_i;
    end

    // R2: a trigger edge puts the leading identifier bit on the line.
    assert_trig_loads_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !$past(trig_i)) |=> (!sel_evt || sout_o == $past(board_id_i[ID_W-1])));

    // R3: with no load and no shift, the selected card's output holds.
    assert_hold_without_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_evt && !(trig_i && !$past(trig_i)) && !(!sclk_i && $past(sclk_i)))
        |=> (!sel_evt || $stable(sout_o)));

    // R7: once at the final signal, further steps keep it there.
    assert_saturate_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_last_o && !mrst_i) |=> (!sel_mon || mon_last_o));

    // R8: a monitor reset leaves the final-signal flag low.
    assert_reset_to_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mon && mrst_i) |=> !mon_last_o);

    // R9: only a card selected for monitoring can flag the final signal.
    assert_last_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mon_last_o |-> sel_mon);
endmodule

bind fe_readout_slave fe_readout_slave_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .board_id_i (board_id_i),
    .my_addr_i  (my_addr_i),
    .addr_i     (addr_i),
    .mode_evt_i (mode_evt_i),
    .trig_i     (trig_i),
    .sclk_i     (sclk_i),
    .mrst_i     (mrst_i),
    .sout_o     (sout_o),
    .mon_last_o (mon_last_o)
);

// File: tb/fe_readout_slave_test.sv
// Self-checking bench for fe_readout_slave.
module fe_readout_slave_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  board_id_i;
    logic [3:0]  my_addr_i, addr_i;
    logic        mode_evt_i, trig_i, tdc_i, sclk_i, sin_i, mclk_i, mrst_i, min_i;
    logic [31:0] hits_i;
    logic [3:0]  fold_i;
    logic [2:0]  cal_i;
    logic        sout_o, mout_o, mon_last_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    fe_readout_slave uut (
        .clk(clk), .rst_n(rst_n), .board_id_i(board_id_i), .my_addr_i(my_addr_i),
        .addr_i(addr_i), .mode_evt_i(mode_evt_i), .trig_i(trig_i), .hits_i(hits_i),
        .fold_i(fold_i), .tdc_i(tdc_i), .cal_i(cal_i), .sclk_i(sclk_i), .sin_i(sin_i),
        .sout_o(sout_o), .mclk_i(mclk_i), .mrst_i(mrst_i), .min_i(min_i),
        .mout_o(mout_o), .mon_last_o(mon_last_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Stimulus table: {board id, hits, folds, tdc}; the frame appends 3 zeros.
    localparam logic [44:0] VEC [0:5] = '{
        {8'h5A, 32'h0000_0001, 4'b0000, 1'b0},
        {8'h81, 32'h8000_0000, 4'b1000, 1'b1},
        {8'hFF, 32'hFFFF_FFFF, 4'b1111, 1'b1},
        {8'h00, 32'h0000_0000, 4'b0000, 1'b0},
        {8'h3C, 32'hA5C3_9E17, 4'b0110, 1'b0},
        {8'hC7, 32'h1234_5678, 4'b1001, 1'b1}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic trig_pulse();
        trig_i = 1'b1; step();
        trig_i = 1'b0; step();
    endtask

    task automatic sclk_pulse();
        sclk_i = 1'b1; step();
        sclk_i = 1'b0; step();
    endtask

    task automatic mclk_pulse();
        mclk_i = 1'b1; step();
        mclk_i = 1'b0; step();
    endtask

    task automatic apply(input logic [44:0] v);
        {board_id_i, hits_i, fold_i, tdc_i} = v;
    endtask

    task automatic read_frame(output logic [47:0] got);
        got[47] = sout_o;
        for (int i = 46; i >= 0; i--) begin
            sclk_pulse();
            got[i] = sout_o;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] got;
        logic [39:0] mon_exp;
        rst_n = 1'b0; my_addr_i = 4'd5; addr_i = 4'd5; mode_evt_i = 1'b1;
        trig_i = 0; sclk_i = 0; sin_i = 0; mclk_i = 0; mrst_i = 0; min_i = 1'b1;
        board_id_i = 8'h00; hits_i = '0; fold_i = '0; tdc_i = 0; cal_i = '0;
        repeat (3) step();
        rst_n = 1'b1; step();

        // R1: the frame register is cleared by reset
        check(sout_o == 1'b0, "R1 frame cleared", 64'(sout_o), 64'd0);
        mode_evt_i = 1'b0; step();
        check(mon_last_o == 1'b0 && mout_o == min_i, "R1 monitor idle",
              {62'd0, mon_last_o, mout_o}, {62'd0, 1'b0, min_i});

        // R2 R3: table-driven loads and full readouts
        mode_evt_i = 1'b1; step();
        for (int v = 0; v < 6; v++) begin
            apply(VEC[v]);
            trig_pulse();
            read_frame(got);
            check(got == {VEC[v], 3'b000}, "R2/R3 frame readout", 64'(got), 64'({VEC[v], 3'b000}));
        end

        // R3: after 48 shifts the upstream data reaches the output
        apply(VEC[2]); trig_pulse();
        sin_i = 1'b1;
        for (int i = 0; i < 48; i++) sclk_pulse();
        check(sout_o == 1'b1, "R3 upstream fill", 64'(sout_o), 64'd1);
        sin_i = 1'b0;

        // R4: a deselected card bypasses and ignores the serial clock
        addr_i = 4'd3; sin_i = 1'b1; step();
        check(sout_o == 1'b1, "R4 bypass high", 64'(sout_o), 64'd1);
        sin_i = 1'b0; step();
        check(sout_o == 1'b0, "R4 bypass low", 64'(sout_o), 64'd0);
        apply(VEC[4]); trig_pulse();  // R2: the load also happens when not addressed
        for (int i = 0; i < 5; i++) sclk_pulse();
        addr_i = 4'd5; step();
        read_frame(got);
        check(got == {VEC[4], 3'b000}, "R4 no shift while deselected", 64'(got), 64'({VEC[4], 3'b000}));

        // R2: a trigger in monitor mode still loads the frame
        mode_evt_i = 1'b0; apply(VEC[5]); trig_pulse();
        mode_evt_i = 1'b1; step();
        read_frame(got);
        check(got == {VEC[5], 3'b000}, "R2 load in monitor mode", 64'(got), 64'({VEC[5], 3'b000}));

        // R5 R6 R7: step through all monitor signals
        hits_i = 32'hA5C3_9E17; fold_i = 4'b1001; tdc_i = 1'b1; cal_i = 3'b010;
        mon_exp = {cal_i, tdc_i, fold_i, hits_i};
        mode_evt_i = 1'b0; min_i = 1'b0; step();
        check(mout_o == 1'b0, "R5 forwards before enable", 64'(mout_o), 64'd0);
        min_i = 1'b1; step();
        check(mout_o == 1'b1, "R5 forwards before enable", 64'(mout_o), 64'd1);
        mclk_pulse();
        check(mout_o == mon_exp[0], "R5 first signal", 64'(mout_o), 64'(mon_exp[0]));
        for (int k = 1; k < 40; k++) begin
            mclk_pulse();
            check(mout_o == mon_exp[k] && mon_last_o == (k == 39), "R6 advance",
                  {62'd0, mon_last_o, mout_o}, {62'd0, 1'(k == 39), mon_exp[k]});
        end
        for (int k = 0; k < 3; k++) begin
            mclk_pulse();
            check(mon_last_o == 1'b1 && mout_o == mon_exp[39], "R7 saturate",
                  {62'd0, mon_last_o, mout_o}, {62'd0, 1'b1, mon_exp[39]});
        end

        // R8: monitor reset returns to the first signal and keeps the enable
        mrst_i = 1'b1; mclk_i = 1'b1; step();
        mrst_i = 1'b0; mclk_i = 1'b0; step();
        check(mon_last_o == 1'b0 && mout_o == mon_exp[0], "R8 reset to first",
              {62'd0, mon_last_o, mout_o}, {62'd0, 1'b0, mon_exp[0]});
        mclk_pulse();
        check(mout_o == mon_exp[1], "R8 still enabled", 64'(mout_o), 64'(mon_exp[1]));

        // R9: a deselected card forwards and needs a new enabling pulse
        addr_i = 4'd6; min_i = 1'b0; step();
        check(mout_o == 1'b0 && mon_last_o == 1'b0, "R9 forward when deselected",
              {62'd0, mon_last_o, mout_o}, 64'd0);
        mclk_pulse(); mclk_pulse();
        addr_i = 4'd5; step();
        check(mout_o == 1'b0, "R9 enable dropped", 64'(mout_o), 64'd0);
        mclk_pulse();
        check(mout_o == mon_exp[0], "R9 re-enable at first", 64'(mout_o), 64'(mon_exp[0]));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule